// File: doc/BRIEF.md
# Output Impedance Calibration Sequencer

This block is the digital half of an output-driver impedance calibration loop. A free-running timer opens an evaluation window every 32 clocks. At that moment the block samples an external comparator. The comparator reports whether the driver impedance is above or below its target. The result becomes a single pending step on a 6-bit drive-strength code. The step is committed only on a clock where the data bus is in high-Z, which happens in write, deselect or output-disabled cycles. Because of this, the code never moves while the pins are actively driving read data.

A separate count of high-Z (non-read) cycles decides when the loop has had enough opportunities to settle. After 1024 such cycles a sticky `calibrated` flag is raised. A mode input forces the drivers to maximum strength, which is the minimum-impedance setting. While that mode is active the loop is frozen and any pending step is discarded.

Top module: `zcal_sequencer`

## Requirements
- R1: The comparator is evaluated on the 32nd rising clock edge after reset is released, and on every 32nd edge after that. A sampled `cmp_high` of 1 requests a step of +1 on the code, and 0 requests a step of -1.
- R2: Between two evaluations the drive code moves by at most one step.
- R3: A pending step is committed on the first rising edge where `bus_hiz` is 1. While `bus_hiz` is 0 the code does not change.
- R4: An evaluation that arrives while an earlier step is still pending replaces that step. The older step is never applied.
- R5: The code saturates at 63 (a further +1 keeps 63) and at 0 (a further -1 keeps 0). It never wraps.
- R6: During reset and directly after it, `drive_code` is 32 and `calibrated` is 0.
- R7: While `min_z_mode` is 1, `drive_code` reads 63 and the internal code is frozen. Any pending step is discarded and no new step is kept. When the mode is left, the code from before the mode returns.
- R8: `calibrated` is 0 until 1024 rising edges with `bus_hiz` = 1 have been seen since reset, whether consecutive or not. It becomes 1 right after the 1024th such edge.
- R9: Once set, `calibrated` stays 1 until reset, whatever the bus does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_high | input | 1 | Comparator result: 1 means impedance above target (drive stronger) |
| bus_hiz | input | 1 | 1 when the data bus is in high-Z (non-read cycle) |
| min_z_mode | input | 1 | 1 selects fixed minimum impedance and bypasses calibration |
| drive_code | output | 6 | Driver strength code applied to the output legs |
| calibrated | output | 1 | Sticky flag: enough non-read cycles have passed since reset |

## Verification
The bench first checks that a step held back during a driving stretch lands on the first high-Z edge. A design that applied it immediately would move the code under read data. It then checks that a second evaluation overwrites the held step. A design that queued both steps would end two codes away, not one.

The saturation runs push the code into both rails. An off-by-one limit would show up there as a wrap to the opposite end. The calibration test probes 1023 versus 1024 high-Z edges with a driving cycle in between, which catches a flag that fires early or counts every cycle. The minimum-impedance rows check that leaving the mode restores the earlier code and does not apply a stale step.

// File: rtl/zcal_pkg.sv
// Package: shared types for the impedance calibration sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package zcal_pkg;

    // Direction of one code step requested by an evaluation.
    typedef enum logic {
        STEP_DOWN = 1'b0,
        STEP_UP   = 1'b1
    } step_dir_e;

endpackage

// File: rtl/zcal_eval_timer.sv
// Module: zcal_eval_timer
// Produces a one-cycle evaluation strobe once every EVAL_PERIOD clocks.
// The first strobe is asserted in the cycle before the EVAL_PERIOD-th
// edge after reset, so the comparator is sampled on that edge.
// Assumes: EVAL_PERIOD >= 2.
module zcal_eval_timer #(
    parameter int EVAL_PERIOD = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic eval_tick
);
    localparam int CNT_W = (EVAL_PERIOD > 2) ? $clog2(EVAL_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EVAL_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Strobe when the period counter sits on its last value.
    assign eval_tick = (cnt_q == LAST);

    // Period counter, wraps to zero after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (eval_tick) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // R1: strobe is a single-cycle pulse
    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        eval_tick |=> !eval_tick);

endmodule

// File: rtl/zcal_step_holder.sv
// Module: zcal_step_holder
// Holds the step decided by the latest evaluation until it can be
// committed on a high-Z bus cycle. A newer evaluation overwrites the
// held step. Minimum-impedance mode discards the held step.
// Assumes: eval_tick is a single-cycle strobe.
module zcal_step_holder
    import zcal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      eval_tick,
    input  logic      cmp_high,
    input  logic      bus_hiz,
    input  logic      min_z_mode,
    output logic      step_apply,
    output step_dir_e step_dir
);
    logic      pend_valid_q;
    step_dir_e pend_dir_q;

    // Commit only when a step waits, the bus is idle and calibration runs.
    assign step_apply = pend_valid_q && bus_hiz && !min_z_mode;
    assign step_dir   = pend_dir_q;

    // Pending flag: mode clears, evaluation loads, commit consumes.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_valid_q <= 1'b0;
        else if (min_z_mode) pend_valid_q <= 1'b0;
        else if (eval_tick)  pend_valid_q <= 1'b1;
        else if (step_apply) pend_valid_q <= 1'b0;
    end

    // Pending direction: captured from the comparator at each evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pend_dir_q <= STEP_DOWN;
        else if (eval_tick && !min_z_mode) pend_dir_q <= cmp_high ? STEP_UP : STEP_DOWN;
    end

    // R4: a step only becomes pending at an evaluation
    a_r4_load_on_eval: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_valid_q) |-> $past(eval_tick));

    // R7: nothing is held across a minimum-impedance cycle
    a_r7_mode_discards: assert property (@(posedge clk) disable iff (!rst_n)
        $past(min_z_mode) |-> !pend_valid_q);

endmodule

// File: rtl/zcal_code_reg.sv
// Module: zcal_code_reg
// Saturating up/down register holding the driver strength code.
// Assumes: step_apply is asserted at most once per evaluation period.
module zcal_code_reg
    import zcal_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_apply,
    input  step_dir_e         step_dir,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] CODE_MAX   = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_MIN   = '0;
    localparam logic [CODE_W-1:0] CODE_RESET = CODE_W'(1) << (CODE_W - 1);

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_d;

    assign code = code_q;

    // Next code: one step in the requested direction, clamped at the rails.
    always_comb begin
        code_d = code_q;
        if (step_apply) begin
            if (step_dir == STEP_UP) begin
                if (code_q != CODE_MAX) code_d = code_q + 1'b1;
            end else begin
                if (code_q != CODE_MIN) code_d = code_q - 1'b1;
            end
        end
    end

    // Code register, mid-scale after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= CODE_RESET;
        else        code_q <= code_d;
    end

    // R2 / R5: every change is exactly one step, so no wrap between rails
    a_r2_one_step_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |->
            ((code_q == $past(code_q) + 1'b1) && ($past(code_q) != CODE_MAX)) ||
            ((code_q == $past(code_q) - 1'b1) && ($past(code_q) != CODE_MIN)));

endmodule

// File: rtl/zcal_cert_counter.sv
// Module: zcal_cert_counter
// Counts clocks with the bus in high-Z and raises a sticky flag once
// CERT_CYCLES of them have been seen since reset.
// Assumes: CERT_CYCLES >= 1.
module zcal_cert_counter #(
    parameter int CERT_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_hiz,
    output logic calibrated
);
    localparam int CNT_W = $clog2(CERT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CERT_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    assign calibrated = (cnt_q == LIMIT);

    // Non-read cycle counter, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (bus_hiz && !calibrated) cnt_q <= cnt_q + 1'b1;
    end

    // R9: the flag never drops outside reset
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(calibrated) |-> calibrated);

    // R8: the flag can only rise on a high-Z edge
    a_r8_rise_on_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(calibrated) |-> $past(bus_hiz));

endmodule

// File: rtl/zcal_sequencer.sv
// Module: zcal_sequencer (top)
// Periodic output-impedance calibration: evaluation timer, pending
// step holder, saturating code register and non-read certification
// counter. Minimum-impedance mode forces the strongest code.
// Assumes: cmp_high is already synchronous to clk.
module zcal_sequencer
    import zcal_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int EVAL_PERIOD = 32,
    parameter int CERT_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_high,
    input  logic              bus_hiz,
    input  logic              min_z_mode,
    output logic [CODE_W-1:0] drive_code,
    output logic              calibrated
);
    localparam logic [CODE_W-1:0] CODE_STRONGEST = {CODE_W{1'b1}};

    logic              eval_tick;
    logic              step_apply;
    step_dir_e         step_dir;
    logic [CODE_W-1:0] core_code;

    zcal_eval_timer #(.EVAL_PERIOD(EVAL_PERIOD)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_tick (eval_tick)
    );

    zcal_step_holder u_holder (
        .clk        (clk),
        .rst_n      (rst_n),
        .eval_tick  (eval_tick),
        .cmp_high   (cmp_high),
        .bus_hiz    (bus_hiz),
        .min_z_mode (min_z_mode),
        .step_apply (step_apply),
        .step_dir   (step_dir)
    );

    zcal_code_reg #(.CODE_W(CODE_W)) u_code (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_apply (step_apply),
        .step_dir   (step_dir),
        .code       (core_code)
    );

    zcal_cert_counter #(.CERT_CYCLES(CERT_CYCLES)) u_cert (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_hiz    (bus_hiz),
        .calibrated (calibrated)
    );

    // Output select: fixed strongest code in minimum-impedance mode.
    assign drive_code = min_z_mode ? CODE_STRONGEST : core_code;

    // R3: the code holds whenever the bus was driving on the last edge
    a_r3_hold_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_hiz) |-> $stable(core_code));

    // R7: the calibrated code is frozen across minimum-impedance cycles
    a_r7_frozen_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $past(min_z_mode) |-> $stable(core_code));

endmodule

// File: tb/zcal_sequencer_tb.sv
module zcal_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 32;
    localparam int CMAX       = 63;

    // Row format {cmp_high, bus_hiz, min_z_mode}; each row lasts PERIOD clocks.
    localparam logic [2:0] VEC [24] = '{
        3'b110, 3'b110, 3'b110, 3'b010, 3'b100, 3'b110, 3'b010, 3'b000,
        3'b010, 3'b111, 3'b110, 3'b110, 3'b101, 3'b011, 3'b110, 3'b100,
        3'b100, 3'b010, 3'b110, 3'b111, 3'b011, 3'b010, 3'b110, 3'b110
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_high = 1'b0;
    logic       bus_hiz = 1'b0;
    logic       min_z_mode = 1'b0;
    logic [5:0] drive_code;
    logic       calibrated;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    zcal_sequencer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_high   (cmp_high),
        .bus_hiz    (bus_hiz),
        .min_z_mode (min_z_mode),
        .drive_code (drive_code),
        .calibrated (calibrated)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmp_high = 1'b0; bus_hiz = 1'b0; min_z_mode = 1'b0;
        run(3);
        check("R6 reset code", int'(drive_code), 32);
        check("R6 reset flag", int'(calibrated), 0);
        rst_n = 1'b1;
    endtask

    function automatic int step_sat(input int c, input bit up);
        if (up) return (c == CMAX) ? CMAX : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    initial begin
        int exp_code;
        int hiz_tot;
        bit have_prev;
        bit prev_cmp;

        // Table walk: step timing, pending hold (R3), mode (R7), flag not early (R8).
        do_reset();
        exp_code = 32; hiz_tot = 0; have_prev = 0; prev_cmp = 0;
        for (int i = 0; i < 24; i++) begin
            logic [2:0] v;
            v = VEC[i];
            cmp_high = v[2]; bus_hiz = v[1]; min_z_mode = v[0];
            run(PERIOD);
            if (!v[0] && v[1] && have_prev) exp_code = step_sat(exp_code, prev_cmp);
            if (v[1]) hiz_tot += PERIOD;
            check(v[0] ? "R7 mode code" : "R1 R3 row code", int'(drive_code),
                  v[0] ? CMAX : exp_code);
            check("R8 flag in table", int'(calibrated), (hiz_tot >= 1024) ? 1 : 0);
            prev_cmp  = v[2];
            have_prev = !v[0];
        end

        // Directed: hold, replacement, single step.
        do_reset();
        cmp_high = 1'b1; bus_hiz = 1'b0;
        run(PERIOD);
        check("R3 held while driving", int'(drive_code), 32);
        cmp_high = 1'b0;
        run(PERIOD);
        check("R3 still held", int'(drive_code), 32);
        bus_hiz = 1'b1;
        run(1);
        check("R4 newer step replaces older", int'(drive_code), 31);
        run(PERIOD - 2);
        check("R2 one step per evaluation", int'(drive_code), 31);

        // Directed: rails.
        do_reset();
        cmp_high = 1'b1; bus_hiz = 1'b1;
        run(40 * PERIOD);
        check("R5 upper rail", int'(drive_code), CMAX);
        check("R8 flag after many hiz", int'(calibrated), 1);
        cmp_high = 1'b0;
        run(70 * PERIOD);
        check("R5 lower rail", int'(drive_code), 0);
        check("R9 flag sticky", int'(calibrated), 1);

        // Directed: calibration boundary.
        do_reset();
        bus_hiz = 1'b1;
        run(1023);
        check("R8 not at 1023", int'(calibrated), 0);
        bus_hiz = 1'b0;
        run(1);
        check("R8 read cycle not counted", int'(calibrated), 0);
        bus_hiz = 1'b1;
        run(1);
        check("R8 set at 1024", int'(calibrated), 1);
        bus_hiz = 1'b0;
        run(100);
        check("R9 stays set", int'(calibrated), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule